// File: doc/BRIEF.md
# Shared Interrupt Source Conditioner

This block takes in a bank of external interrupt lines and turns each one into a pending bit. It holds the per-line configuration and state that an interrupt controller needs before routing happens. Each line passes through a two-flop synchroniser. It is then qualified as either a level (active high or active low) or an edge (rising, falling or both). Level pending bits track the qualified input. Edge pending bits latch and stay set until software clears them.

Software reaches the block through a simple 32-bit word-addressed register port with no wait states. Writes complete in the cycle that `bus_req_i && bus_we_i` is high. Read data is combinational from the current address.

Per-source bit arrays are packed 32 sources per word, and consecutive words sit at a 4-byte stride. The port carries word addresses, so the byte offset is 4 × the word address. Bits [6:4] of the word address select a bank and bits [3:0] select a word inside it.

The banks are:
- 0 (byte 0x000): polarity.
- 1 (0x040): trigger.
- 2 (0x080): dual edge.
- 3 (0x0C0): mask set.
- 4 (0x100): mask clear.
- 5 (0x140): pending.
- 6 (0x180): software edge.

The output `irq_vec_o` is the pending vector ANDed with the mask. It feeds a routing and selection stage outside this block.

Top module: `irq_src_cond`

## Requirements
- R1: After reset every polarity bit reads 1, and every trigger, dual-edge and mask bit reads 0. Pending reads 0 while the inputs are low, and `irq_vec_o` is 0.
- R2: Writing word w of bank 3 enables source 32w+n for each set bit n. Zero bits leave their mask bits unchanged. Banks 3 and 4 both read back the current mask word.
- R3: Writing word w of bank 4 disables source 32w+n for each set bit n. Zero bits leave their mask bits unchanged.
- R4: Banks 0, 1 and 2 are read/write. Bit n of word w holds source 32w+n. Polarity 1 means positive and 0 means negative. Trigger 1 means edge and 0 means level. Dual 1 means both edges. Words at or beyond N_SRC/32 read 0 and ignore writes.
- R5: A level source (trigger 0) has pending equal to its input when polarity is 1, and to the inverted input when polarity is 0. Pending changes on the third rising clock edge after the input changes.
- R6: An edge source with dual 0 sets pending on a rising input when polarity is 1 and on a falling input when polarity is 0. It ignores the opposite edge, and pending then holds until it is cleared.
- R7: An edge source with dual 1 sets pending on both rising and falling inputs, whatever its polarity bit.
- R8: A write to bank 6 word 0 names a source in bits [7:0]. Bit 31 = 1 sets that source's pending bit and bit 31 = 0 clears it. This applies to edge sources only. Numbers at or above N_SRC are ignored, and level sources keep following their input.
- R9: `irq_vec_o` equals pending AND mask. Bank 5 reads the raw pending bits whatever the mask.
- R10: When a software clear and a detected edge hit the same source in the same cycle, pending ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | N_SRC | Raw interrupt inputs, asynchronous |
| bus_req_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 7 | Word address: [6:4] bank, [3:0] word |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the current address |
| irq_vec_o | output | N_SRC | Pending AND mask per source |

## Verification
The bench builds the block with N_SRC = 64, so there are two words per bank. This makes the 4-byte stride reachable, along with the upper-word decode and the out-of-range software source numbers. Sources 0 to 6 are set up once as the six trigger flavours (level high, level low, rising, falling, and two dual-edge with opposite polarity) plus one edge source for software use. This lets one input pattern exercise all the qualification paths. A timed input step pins the three-edge latency, and a software clear placed exactly on the detecting edge exercises the set-beats-clear rule.

// File: rtl/irq_cond_pkg.sv
`timescale 1ns/1ps
package irq_cond_pkg;
  localparam int BUS_AW      = 7;
  localparam int WORD_W      = 4;
  localparam int SWE_ID_W    = 8;
  localparam int SWE_SET_BIT = 31;

  typedef enum logic [2:0] {
    BANK_POL  = 3'd0,
    BANK_TRIG = 3'd1,
    BANK_DUAL = 3'd2,
    BANK_MSET = 3'd3,
    BANK_MCLR = 3'd4,
    BANK_PEND = 3'd5,
    BANK_SWE  = 3'd6,
    BANK_NONE = 3'd7
  } bank_e;
endpackage

// File: rtl/irq_cfg_regs.sv
`timescale 1ns/1ps
module irq_cfg_regs import irq_cond_pkg::*; #(
  parameter int N_SRC = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  bank_e             bank_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [31:0]       wdata_i,
  output logic [N_SRC-1:0]  pol_o,
  output logic [N_SRC-1:0]  trig_o,
  output logic [N_SRC-1:0]  dual_o,
  output logic [N_SRC-1:0]  mask_o
);
  localparam int NW = N_SRC / 32;

  logic [31:0] pol_w  [NW];
  logic [31:0] trig_w [NW];
  logic [31:0] dual_w [NW];
  logic [31:0] mask_w [NW];

  for (genvar w = 0; w < NW; w++) begin : g_word
    logic hit;
    assign hit = wr_i && (word_i == WORD_W'(w));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pol_w[w]  <= '1;
        trig_w[w] <= '0;
        dual_w[w] <= '0;
        mask_w[w] <= '0;
      end else if (hit) begin
        case (bank_i)
          BANK_POL:  pol_w[w]  <= wdata_i;
          BANK_TRIG: trig_w[w] <= wdata_i;
          BANK_DUAL: dual_w[w] <= wdata_i;
          BANK_MSET: mask_w[w] <= mask_w[w] | wdata_i;
          BANK_MCLR: mask_w[w] <= mask_w[w] & ~wdata_i;
          default: ;
        endcase
      end
    end

    assign pol_o[w*32 +: 32]  = pol_w[w];
    assign trig_o[w*32 +: 32] = trig_w[w];
    assign dual_o[w*32 +: 32] = dual_w[w];
    assign mask_o[w*32 +: 32] = mask_w[w];
  end

  AST_MSET_NO_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && bank_i == BANK_MSET) |=> ((mask_o & $past(mask_o)) == $past(mask_o))); // R2
  AST_MSET_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && bank_i == BANK_MSET && word_i == '0) |=>
      ((mask_o[31:0] & $past(wdata_i)) == $past(wdata_i))); // R2
  AST_MCLR_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && bank_i == BANK_MCLR) |=> ((mask_o | $past(mask_o)) == $past(mask_o))); // R3
endmodule

// File: rtl/irq_src_cell.sv
`timescale 1ns/1ps
module irq_src_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic pol_i,
  input  logic edge_i,
  input  logic dual_i,
  input  logic sw_set_i,
  input  logic sw_clr_i,
  output logic pend_o
);
  logic sync1_q, sync2_q, prev_q, pend_q, pend_d;
  logic rise, fall, hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      sync1_q <= src_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      pend_q  <= pend_d;
    end
  end

  assign rise = sync2_q & ~prev_q;
  assign fall = ~sync2_q & prev_q;
  assign hit  = dual_i ? (rise | fall) : (pol_i ? rise : fall);

  // edge: detected edge and software set beat software clear
  always_comb begin
    if (edge_i) pend_d = hit | sw_set_i | (pend_q & ~sw_clr_i);
    else        pend_d = pol_i ? sync2_q : ~sync2_q;
  end

  assign pend_o = pend_q;

  AST_EDGE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i && pend_q && !sw_clr_i) |=> pend_q); // R6
  AST_DUAL_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i && dual_i && (sync2_q != prev_q)) |=> pend_q); // R7
  AST_SW_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i && sw_set_i) |=> pend_q); // R8
  AST_LVL_NO_SW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!edge_i && sw_set_i && (pol_i != sync2_q)) |=> !pend_q); // R8
  AST_ACK_LOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i && sw_clr_i && (sync2_q != prev_q) && (dual_i || (pol_i == sync2_q))) |=> pend_q); // R10
endmodule

// File: rtl/irq_src_cond.sv
`timescale 1ns/1ps
module irq_src_cond import irq_cond_pkg::*; #(
  parameter int N_SRC = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic [N_SRC-1:0]  irq_vec_o
);
  localparam int NW = N_SRC / 32;

  bank_e             bank;
  logic [WORD_W-1:0] word;
  logic              wr, swe_wr;
  logic [N_SRC-1:0]  pol, trig, dual, mask, pend, sw_set, sw_clr;

  assign bank   = bank_e'(bus_addr_i[BUS_AW-1 -: 3]);
  assign word   = bus_addr_i[WORD_W-1:0];
  assign wr     = bus_req_i && bus_we_i;
  assign swe_wr = wr && (bank == BANK_SWE) && (word == '0);

  irq_cfg_regs #(.N_SRC(N_SRC)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr),
    .bank_i  (bank),
    .word_i  (word),
    .wdata_i (bus_wdata_i),
    .pol_o   (pol),
    .trig_o  (trig),
    .dual_o  (dual),
    .mask_o  (mask)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic id_hit;
    assign id_hit    = swe_wr && (bus_wdata_i[SWE_ID_W-1:0] == SWE_ID_W'(i));
    assign sw_set[i] = id_hit && bus_wdata_i[SWE_SET_BIT];
    assign sw_clr[i] = id_hit && !bus_wdata_i[SWE_SET_BIT];

    irq_src_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .src_i    (src_i[i]),
      .pol_i    (pol[i]),
      .edge_i   (trig[i]),
      .dual_i   (dual[i]),
      .sw_set_i (sw_set[i]),
      .sw_clr_i (sw_clr[i]),
      .pend_o   (pend[i])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    if (int'(word) < NW) begin
      case (bank)
        BANK_POL:             bus_rdata_o = pol[{word, 5'd0} +: 32];
        BANK_TRIG:            bus_rdata_o = trig[{word, 5'd0} +: 32];
        BANK_DUAL:            bus_rdata_o = dual[{word, 5'd0} +: 32];
        BANK_MSET, BANK_MCLR: bus_rdata_o = mask[{word, 5'd0} +: 32];
        BANK_PEND:            bus_rdata_o = pend[{word, 5'd0} +: 32];
        default:              bus_rdata_o = '0;
      endcase
    end
  end

  assign irq_vec_o = pend & mask;

  AST_VEC_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_vec_o & ~mask) == '0)); // R9
  AST_SW_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($onehot0(sw_set | sw_clr))); // R8
endmodule

// File: tb/sim_irq_src_cond.sv
`timescale 1ns/1ps
module sim_irq_src_cond;
  localparam int N  = 64;
  localparam int NW = N / 32;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [N-1:0] src = '0;
  logic req = 1'b0, we = 1'b0;
  logic [6:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N-1:0] vec;

  irq_src_cond #(.N_SRC(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_vec_o(vec)
  );

  int checks = 0, errors = 0;

  // behavioural reference
  logic [N-1:0] m_pol, m_trig, m_dual, m_mask, m_pend;
  logic [N-1:0] m_hist[$];

  always @(posedge clk or negedge rst_n) begin
    logic [N-1:0] s, sd, np;
    int bank, w;
    if (!rst_n) begin
      m_pol = '1; m_trig = '0; m_dual = '0; m_mask = '0; m_pend = '0;
      m_hist = '{'0, '0, '0};
    end else begin
      s = m_hist[1]; sd = m_hist[2];
      bank = int'(addr) / 16; w = int'(addr) % 16;
      for (int i = 0; i < N; i++) begin
        if (m_trig[i]) begin
          logic r, f, h, ss, sc;
          r = s[i] & ~sd[i];
          f = ~s[i] & sd[i];
          h = m_dual[i] ? (r | f) : (m_pol[i] ? r : f);
          ss = req && we && bank == 6 && w == 0 && int'(wdata[7:0]) == i && wdata[31];
          sc = req && we && bank == 6 && w == 0 && int'(wdata[7:0]) == i && !wdata[31];
          np[i] = h | ss | (m_pend[i] & ~sc);
        end else begin
          np[i] = m_pol[i] ? s[i] : ~s[i];
        end
      end
      if (req && we && w < NW) begin
        case (bank)
          0: m_pol[w*32 +: 32] = wdata;
          1: m_trig[w*32 +: 32] = wdata;
          2: m_dual[w*32 +: 32] = wdata;
          3: m_mask[w*32 +: 32] = m_mask[w*32 +: 32] | wdata;
          4: m_mask[w*32 +: 32] = m_mask[w*32 +: 32] & ~wdata;
          default: ;
        endcase
      end
      m_pend = np;
      m_hist.push_front(src);
      void'(m_hist.pop_back());
    end
  end

  function automatic logic [31:0] m_read(int a);
    int bank = a / 16, w = a % 16;
    if (w >= NW) return '0;
    case (bank)
      0: return m_pol[w*32 +: 32];
      1: return m_trig[w*32 +: 32];
      2: return m_dual[w*32 +: 32];
      3, 4: return m_mask[w*32 +: 32];
      5: return m_pend[w*32 +: 32];
      default: return '0;
    endcase
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  bit run_cmp = 0;
  always @(negedge clk) if (run_cmp) chk("R9 vector vs model", vec, m_pend & m_mask);

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = 7'(a); wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd_lit(int a, logic [31:0] exp, string tag);
    @(negedge clk); req = 1; we = 0; addr = 7'(a);
    #1; chk(tag, rdata, exp); chk({tag, " model"}, rdata, m_read(a));
    req = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3); rst_n = 1; run_cmp = 1;
    // R1 reset state
    rd_lit(7'h00, 32'hFFFF_FFFF, "R1 pol w0");
    rd_lit(7'h01, 32'hFFFF_FFFF, "R1 pol w1");
    rd_lit(7'h10, 32'h0, "R1 trig");
    rd_lit(7'h20, 32'h0, "R1 dual");
    rd_lit(7'h30, 32'h0, "R1 mask");
    rd_lit(7'h50, 32'h0, "R1 pend");
    chk("R1 vec", vec, '0);
    // R2 mask set
    wr(7'h30, 32'hF1);
    rd_lit(7'h30, 32'hF1, "R2 set");
    wr(7'h30, 32'h100);
    rd_lit(7'h40, 32'h1F1, "R2 zeros keep");
    wr(7'h31, 32'h8000_0000);
    rd_lit(7'h31, 32'h8000_0000, "R2 word1");
    rd_lit(7'h30, 32'h1F1, "R2 word0 kept");
    // R3 mask clear
    wr(7'h40, 32'h11);
    rd_lit(7'h30, 32'h1E0, "R3 clear");
    rd_lit(7'h31, 32'h8000_0000, "R3 other word");
    // R4 config RW, stride, out-of-range words
    wr(7'h01, 32'h1234_5678);
    rd_lit(7'h01, 32'h1234_5678, "R4 pol w1");
    wr(7'h11, 32'hA5A5_0000);
    rd_lit(7'h11, 32'hA5A5_0000, "R4 trig w1");
    rd_lit(7'h10, 32'h0, "R4 trig w0 kept");
    wr(7'h21, 32'h0F0F_0000);
    rd_lit(7'h21, 32'h0F0F_0000, "R4 dual w1");
    wr(7'h05, 32'h0);
    rd_lit(7'h05, 32'h0, "R4 out of range");
    rd_lit(7'h00, 32'hFFFF_FFFF, "R4 out of range no alias");
    wr(7'h01, 32'hFFFF_FFFF); wr(7'h11, 32'h0); wr(7'h21, 32'h0);
    // src0 lvl high, 1 lvl low, 2 rise, 3 fall, 4/5 dual, 6 sw edge
    wr(7'h00, 32'hFFFF_FFD5); wr(7'h10, 32'h7C); wr(7'h20, 32'h30);
    wr(7'h30, 32'hFFFF_FFFF); wr(7'h31, 32'hFFFF_FFFF);
    idle(4);
    for (int i = 2; i <= 6; i++) wr(7'h60, 32'(i));
    idle(4);
    rd_lit(7'h50, 32'h2, "R5 level low idle");
    // R5 level + latency
    @(negedge clk); src[0] = 1;
    idle(2); chk("R5 latency before", 64'(vec[0]), 64'd0);
    idle(1); chk("R5 latency at 3", 64'(vec[0]), 64'd1);
    src[1] = 1; idle(4);
    rd_lit(7'h50, 32'h1, "R5 level both");
    src[0] = 0; idle(4);
    rd_lit(7'h50, 32'h0, "R5 level follows");
    // R6 single edge
    src[2] = 1; idle(4); src[2] = 0; idle(4);
    rd_lit(7'h50, 32'h4, "R6 rise sticky");
    src[3] = 1; idle(4);
    rd_lit(7'h50, 32'h4, "R6 fall src ignores rise");
    src[3] = 0; idle(4);
    rd_lit(7'h50, 32'hC, "R6 fall");
    wr(7'h60, 32'h2); wr(7'h60, 32'h3);
    rd_lit(7'h50, 32'h0, "R8 ack clears");
    // R7 dual edge
    src[4] = 1; src[5] = 1; idle(4);
    rd_lit(7'h50, 32'h30, "R7 dual rise");
    wr(7'h60, 32'h4); wr(7'h60, 32'h5);
    rd_lit(7'h50, 32'h0, "R7 cleared");
    src[4] = 0; src[5] = 0; idle(4);
    rd_lit(7'h50, 32'h30, "R7 dual fall");
    wr(7'h60, 32'h4); wr(7'h60, 32'h5);
    // R8 software edge
    wr(7'h60, 32'h8000_0006);
    rd_lit(7'h50, 32'h40, "R8 sw set");
    wr(7'h60, 32'h8000_00C8);
    rd_lit(7'h50, 32'h40, "R8 id out of range");
    rd_lit(7'h51, 32'h0, "R8 id out of range w1");
    wr(7'h60, 32'h8000_0000);
    rd_lit(7'h50, 32'h40, "R8 level ignores sw");
    // R9 mask vs raw pending
    wr(7'h40, 32'h40);
    rd_lit(7'h50, 32'h40, "R9 raw pending");
    chk("R9 masked out", 64'(vec[6]), 64'd0);
    wr(7'h30, 32'h40);
    chk("R9 unmasked", 64'(vec[6]), 64'd1);
    wr(7'h60, 32'h6);
    rd_lit(7'h50, 32'h0, "R8 sw clear");
    // R10 clear lands on detecting edge
    @(negedge clk); src[2] = 1;
    @(negedge clk);
    wr(7'h60, 32'h2);
    rd_lit(7'h50, 32'h4, "R10 edge beats clear");
    chk("R10 vec", 64'(vec[2]), 64'd1);
    idle(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule